// File: doc/BRIEF.md
# Trigger Edge Counting Unit

This unit counts rising edges on a bank of trigger inputs (eight by default). Each channel has its own counter, a snapshot register and a threshold register. The counters run only on the system clock. Each trigger is treated as asynchronous data: it passes through a synchronizer, and edges are then detected in the clock domain. Nothing is clocked by a trigger line.

A sequencer drives the unit through a one-cycle command port with a channel select. The commands are:
- clear a counter;
- take a snapshot of a counter;
- test a snapshot against its threshold, which sets or clears a shared flag;
- request a branch, which is taken when that flag is set;
- store a snapshot to memory.

A store presents a valid/ready write to memory. The address comes from an accumulator, which steps by one after each accepted write. While the write is outstanding, the unit raises a stall request toward instruction fetch so that fetch holds its current address. The threshold registers and the accumulator each have a synchronous load input of their own.

Top module: `trig_count_unit`

## Requirements
- R1: Each channel has an independent counter. Edges on one trigger never change another channel's counter.
- R2: A counter increments once for each rising edge of its trigger, after a two-flop synchronizer, so the increment lands on the third rising clock edge after the trigger rises. A trigger held high counts once. Counters wrap to zero past their maximum value.
- R3: Command code 0 (clear) zeroes the selected counter. A trigger edge detected in the same cycle as the clear is dropped and is not applied later.
- R4: Command code 1 (snapshot) copies the selected counter's value, as held before that clock edge, into the channel's snapshot register. Later edges do not change the snapshot.
- R5: Command code 3 (test) sets `cmp_flag` to 1 when the selected snapshot is greater than or equal to the selected threshold (unsigned), and to 0 otherwise. `thr_load` writes `thr_value` into the threshold register of channel `thr_chan`.
- R6: During an accepted command code 4 (branch), `branch_taken` is high in that same cycle exactly when `cmp_flag` is 1, and is low at all other times.
- R7: Command code 2 (store) raises `mem_wr_valid` in the next cycle. The write carries the accumulator value as its address and the selected snapshot as its data. The accumulator steps by one on the cycle the write is accepted (`mem_wr_valid` and `mem_wr_ready` both high).
- R8: `fetch_stall` is high from the cycle after a store is accepted until the write is accepted. In that interval the address and data stay stable, and commands presented are ignored.
- R9: `acc_load` loads `acc_value` into the accumulator. It wins over the step of a write accepted in the same cycle.
- R10: Command codes 5, 6 and 7 have no effect. A command acts only on a cycle where `cmd_valid` is high and no write is pending.
- R11: After reset, counters, snapshots, thresholds, accumulator and `cmp_flag` are zero, and `fetch_stall`, `mem_wr_valid` and `branch_taken` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| trig_in | input | NCH | Asynchronous trigger lines |
| cmd_valid | input | 1 | Command present this cycle |
| cmd_op | input | 3 | Command code (0 clear, 1 snapshot, 2 store, 3 test, 4 branch) |
| cmd_chan | input | log2(NCH) | Channel the command applies to |
| thr_load | input | 1 | Write a threshold register |
| thr_chan | input | log2(NCH) | Channel of the threshold write |
| thr_value | input | CW | Threshold value |
| acc_load | input | 1 | Load the address accumulator |
| acc_value | input | AW | Accumulator load value |
| mem_wr_ready | input | 1 | Memory accepts the write |
| fetch_stall | output | 1 | Holds instruction fetch during a store |
| branch_taken | output | 1 | Branch command taken |
| cmp_flag | output | 1 | Result of the last test command |
| mem_wr_valid | output | 1 | Memory write pending |
| mem_wr_addr | output | AW | Memory write address |
| mem_wr_data | output | CW | Memory write data |

## Verification
On every cycle, the assertions check these properties:
- each counter only holds, steps by one or returns to zero;
- a snapshot equals the counter value from the cycle before;
- a pending write keeps its address and data until it is accepted;
- the accumulator steps past the written address;
- a taken branch always has the flag set.

Only the directed scenarios can show the end-to-end behaviour:
- the exact counts for pulse trains and for held levels;
- the edge dropped when it meets a clear, and wrap-around;
- that commands issued during a stall leave the counters untouched;
- the load-over-step priority of the accumulator, and the behaviour of unused command codes.

// File: rtl/trig_count_pkg.sv
// Shared definitions for the trigger edge counting unit.
// Assumes: command codes are fixed by the sequencer's instruction encoding.
package trig_count_pkg;
    typedef enum logic [2:0] {
        OP_CLEAR  = 3'd0,
        OP_SNAP   = 3'd1,
        OP_STORE  = 3'd2,
        OP_TEST   = 3'd3,
        OP_BRANCH = 3'd4
    } cnt_op_e;
endpackage

// File: rtl/trig_edge_det.sv
// Brings one asynchronous trigger into the clock domain through a flop chain
// and flags a rising edge for one cycle.
// Assumes: STAGES >= 2; a trigger stays high and low for at least one clock each.
module trig_edge_det #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic trig_in,
    output logic rise
);
    logic [STAGES-1:0] sync_q;
    logic              prev_q;

    // synchronizer chain plus one delayed copy used for edge detection
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sync_q <= '0;
            prev_q <= 1'b0;
        end else begin
            sync_q[0] <= trig_in;
            for (int i = 1; i < STAGES; i++) sync_q[i] <= sync_q[i-1];
            prev_q <= sync_q[STAGES-1];
        end
    end

    assign rise = sync_q[STAGES-1] & ~prev_q;
endmodule

// File: rtl/trig_chan_regs.sv
// Per-channel storage: edge counter, snapshot register and threshold register.
// Assumes: a clear has priority over an increment arriving in the same cycle.
module trig_chan_regs #(
    parameter int CW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          rise,
    input  logic          clr,
    input  logic          snap,
    input  logic          thr_ld,
    input  logic [CW-1:0] thr_val,
    output logic [CW-1:0] cnt_o,
    output logic [CW-1:0] snap_o,
    output logic [CW-1:0] thr_o
);
    // counter: clear wins, otherwise step on each detected edge, wrapping
    always_ff @(posedge clk) begin
        if (!rst_n)    cnt_o <= '0;
        else if (clr)  cnt_o <= '0;
        else if (rise) cnt_o <= cnt_o + 1'b1;
    end

    // snapshot: capture the counter as held before this edge
    always_ff @(posedge clk) begin
        if (!rst_n)    snap_o <= '0;
        else if (snap) snap_o <= cnt_o;
    end

    // threshold: loaded directly from the threshold write port
    always_ff @(posedge clk) begin
        if (!rst_n)      thr_o <= '0;
        else if (thr_ld) thr_o <= thr_val;
    end
endmodule

// File: rtl/trig_mem_writer.sv
// Holds one memory write with valid/ready handshake and the address
// accumulator that steps by one on every accepted write.
// Assumes: start is only raised while no write is pending.
module trig_mem_writer #(
    parameter int AW = 16,
    parameter int CW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic [CW-1:0] start_data,
    input  logic          acc_load,
    input  logic [AW-1:0] acc_value,
    input  logic          mem_wr_ready,
    output logic          mem_wr_valid,
    output logic [AW-1:0] mem_wr_addr,
    output logic [CW-1:0] mem_wr_data,
    output logic [AW-1:0] acc_o
);
    logic accepted;
    assign accepted = mem_wr_valid & mem_wr_ready;

    // pending flag: set on start, cleared by the handshake
    always_ff @(posedge clk) begin
        if (!rst_n)        mem_wr_valid <= 1'b0;
        else if (start)    mem_wr_valid <= 1'b1;
        else if (accepted) mem_wr_valid <= 1'b0;
    end

    // write payload: frozen from start until accepted
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mem_wr_addr <= '0;
            mem_wr_data <= '0;
        end else if (start) begin
            mem_wr_addr <= acc_o;
            mem_wr_data <= start_data;
        end
    end

    // accumulator: load wins over the post-write step
    always_ff @(posedge clk) begin
        if (!rst_n)        acc_o <= '0;
        else if (acc_load) acc_o <= acc_value;
        else if (accepted) acc_o <= acc_o + 1'b1;
    end
endmodule

// File: rtl/trig_count_unit.sv
// Trigger edge counting unit: NCH synchronized edge counters driven by a
// one-cycle command port (clear, snapshot, store, test, branch). A store
// stalls instruction fetch until memory accepts the write.
// Assumes: NCH is a power of two; commands arrive while the stall is high are dropped.
module trig_count_unit
    import trig_count_pkg::*;
#(
    parameter int NCH    = 8,
    parameter int CW     = 32,
    parameter int AW     = 16,
    parameter int STAGES = 2,
    localparam int CHW   = (NCH > 1) ? $clog2(NCH) : 1
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [NCH-1:0] trig_in,
    input  logic           cmd_valid,
    input  logic [2:0]     cmd_op,
    input  logic [CHW-1:0] cmd_chan,
    input  logic           thr_load,
    input  logic [CHW-1:0] thr_chan,
    input  logic [CW-1:0]  thr_value,
    input  logic           acc_load,
    input  logic [AW-1:0]  acc_value,
    input  logic           mem_wr_ready,
    output logic           fetch_stall,
    output logic           branch_taken,
    output logic           cmp_flag,
    output logic           mem_wr_valid,
    output logic [AW-1:0]  mem_wr_addr,
    output logic [CW-1:0]  mem_wr_data
);
    logic [NCH-1:0]         rise;
    logic [NCH-1:0][CW-1:0] cnt_q;
    logic [NCH-1:0][CW-1:0] lat_q;
    logic [NCH-1:0][CW-1:0] thr_q;
    logic [AW-1:0]          acc_q;
    logic                   accept;
    logic                   do_clr, do_snap, do_store, do_test, do_branch;
    logic [CW-1:0]          snap_sel, thr_sel;

    // command acceptance and decode: nothing acts while a write is pending
    always_comb begin
        accept    = cmd_valid & ~mem_wr_valid;
        do_clr    = accept & (cmd_op == OP_CLEAR);
        do_snap   = accept & (cmd_op == OP_SNAP);
        do_store  = accept & (cmd_op == OP_STORE);
        do_test   = accept & (cmd_op == OP_TEST);
        do_branch = accept & (cmd_op == OP_BRANCH);
    end

    // one synchronizer, edge detector and register set per channel
    for (genvar g = 0; g < NCH; g++) begin : g_chan
        trig_edge_det #(.STAGES(STAGES)) u_edge (
            .clk     (clk),
            .rst_n   (rst_n),
            .trig_in (trig_in[g]),
            .rise    (rise[g])
        );
        trig_chan_regs #(.CW(CW)) u_regs (
            .clk     (clk),
            .rst_n   (rst_n),
            .rise    (rise[g]),
            .clr     (do_clr  & (cmd_chan == CHW'(g))),
            .snap    (do_snap & (cmd_chan == CHW'(g))),
            .thr_ld  (thr_load & (thr_chan == CHW'(g))),
            .thr_val (thr_value),
            .cnt_o   (cnt_q[g]),
            .snap_o  (lat_q[g]),
            .thr_o   (thr_q[g])
        );
    end

    // selected channel operands for the shared comparator and the store path
    always_comb begin
        snap_sel = lat_q[cmd_chan];
        thr_sel  = thr_q[cmd_chan];
    end

    // shared flag: takes the result of each test command
    always_ff @(posedge clk) begin
        if (!rst_n)       cmp_flag <= 1'b0;
        else if (do_test) cmp_flag <= (snap_sel >= thr_sel);
    end

    trig_mem_writer #(.AW(AW), .CW(CW)) u_wr (
        .clk          (clk),
        .rst_n        (rst_n),
        .start        (do_store),
        .start_data   (snap_sel),
        .acc_load     (acc_load),
        .acc_value    (acc_value),
        .mem_wr_ready (mem_wr_ready),
        .mem_wr_valid (mem_wr_valid),
        .mem_wr_addr  (mem_wr_addr),
        .mem_wr_data  (mem_wr_data),
        .acc_o        (acc_q)
    );

    assign fetch_stall  = mem_wr_valid;
    assign branch_taken = do_branch & cmp_flag;
endmodule

// File: rtl/trig_count_unit_chk.sv
// Property checker for trig_count_unit, attached with bind.
// Assumes: reaches the unit's internal counter, snapshot and accumulator state.
module trig_count_unit_chk
    import trig_count_pkg::*;
#(
    parameter int NCH  = 8,
    parameter int CW   = 32,
    parameter int AW   = 16,
    localparam int CHW = (NCH > 1) ? $clog2(NCH) : 1
) (
    input logic                   clk,
    input logic                   rst_n,
    input logic                   cmd_valid,
    input logic [2:0]             cmd_op,
    input logic [CHW-1:0]         cmd_chan,
    input logic                   acc_load,
    input logic                   mem_wr_ready,
    input logic                   fetch_stall,
    input logic                   branch_taken,
    input logic                   cmp_flag,
    input logic                   mem_wr_valid,
    input logic [AW-1:0]          mem_wr_addr,
    input logic [CW-1:0]          mem_wr_data,
    input logic [AW-1:0]          acc_q,
    input logic [NCH-1:0][CW-1:0] cnt_q,
    input logic [NCH-1:0][CW-1:0] lat_q
);
    for (genvar g = 0; g < NCH; g++) begin : g_cnt
        // R2/R3: a counter holds, steps by one (wrapping) or returns to zero
        a_r2_count_step: assert property (@(posedge clk) disable iff (!rst_n)
            (cnt_q[g] != $past(cnt_q[g])) |->
                ((cnt_q[g] == CW'($past(cnt_q[g]) + 1'b1)) || (cnt_q[g] == '0)));
    end

    // R4: snapshot equals the counter value before the snapshot edge
    a_r4_snap_copy: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && !fetch_stall && cmd_op == OP_SNAP) |=>
            (lat_q[$past(cmd_chan)] == $past(cnt_q[cmd_chan])));

    // R6: a taken branch needs the flag and a branch command
    a_r6_branch_flag: assert property (@(posedge clk) disable iff (!rst_n)
        branch_taken |-> (cmp_flag && cmd_valid && cmd_op == OP_BRANCH));

    // R8: a pending write keeps its payload until accepted
    a_r8_write_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_wr_valid && !mem_wr_ready) |=>
            (mem_wr_valid && $stable(mem_wr_addr) && $stable(mem_wr_data)));

    // R7: accumulator moves one past the accepted address
    a_r7_acc_step: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_wr_valid && mem_wr_ready && !acc_load) |=>
            (acc_q == AW'($past(mem_wr_addr) + 1'b1)));
endmodule

bind trig_count_unit trig_count_unit_chk #(.NCH(NCH), .CW(CW), .AW(AW)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .cmd_valid    (cmd_valid),
    .cmd_op       (cmd_op),
    .cmd_chan     (cmd_chan),
    .acc_load     (acc_load),
    .mem_wr_ready (mem_wr_ready),
    .fetch_stall  (fetch_stall),
    .branch_taken (branch_taken),
    .cmp_flag     (cmp_flag),
    .mem_wr_valid (mem_wr_valid),
    .mem_wr_addr  (mem_wr_addr),
    .mem_wr_data  (mem_wr_data),
    .acc_q        (acc_q),
    .cnt_q        (cnt_q),
    .lat_q        (lat_q)
);

// File: tb/trig_count_unit_test.sv
// Directed bench: one task per scenario, each checking its own results.
module trig_count_unit_test;
    localparam int CLK_PERIOD = 10;
    localparam int NCH = 8;
    localparam int CW  = 8;
    localparam int AW  = 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [NCH-1:0] trig_in = '0;
    logic          cmd_valid = 1'b0;
    logic [2:0]    cmd_op = '0;
    logic [2:0]    cmd_chan = '0;
    logic          thr_load = 1'b0;
    logic [2:0]    thr_chan = '0;
    logic [CW-1:0] thr_value = '0;
    logic          acc_load = 1'b0;
    logic [AW-1:0] acc_value = '0;
    logic          mem_wr_ready = 1'b0;
    logic          fetch_stall, branch_taken, cmp_flag, mem_wr_valid;
    logic [AW-1:0] mem_wr_addr;
    logic [CW-1:0] mem_wr_data;

    int total = 0;
    int bad = 0;
    int exp_acc = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    trig_count_unit #(.NCH(NCH), .CW(CW), .AW(AW)) uut (
        .clk(clk), .rst_n(rst_n), .trig_in(trig_in),
        .cmd_valid(cmd_valid), .cmd_op(cmd_op), .cmd_chan(cmd_chan),
        .thr_load(thr_load), .thr_chan(thr_chan), .thr_value(thr_value),
        .acc_load(acc_load), .acc_value(acc_value), .mem_wr_ready(mem_wr_ready),
        .fetch_stall(fetch_stall), .branch_taken(branch_taken), .cmp_flag(cmp_flag),
        .mem_wr_valid(mem_wr_valid), .mem_wr_addr(mem_wr_addr), .mem_wr_data(mem_wr_data)
    );

    task automatic check(input string req, input string what, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic issue(input int op, input int ch);
        @(negedge clk);
        cmd_valid = 1'b1; cmd_op = 3'(op); cmd_chan = 3'(ch);
        @(negedge clk);
        cmd_valid = 1'b0;
    endtask

    task automatic pulse(input logic [NCH-1:0] mask);
        @(negedge clk) trig_in = trig_in | mask;
        repeat (2) @(negedge clk);
        trig_in = trig_in & ~mask;
        repeat (3) @(negedge clk);
    endtask

    task automatic store_chk(input int ch, input int exp, input string req);
        issue(2, ch);
        check(req, "store valid", int'(mem_wr_valid), 1);
        check(req, "store addr", int'(mem_wr_addr), exp_acc);
        check(req, "store data", int'(mem_wr_data), exp);
        mem_wr_ready = 1'b1;
        @(negedge clk);
        mem_wr_ready = 1'b0;
        check(req, "valid after accept", int'(mem_wr_valid), 0);
        exp_acc = (exp_acc + 1) % (1 << AW);
    endtask

    task automatic read_chan(input int ch, input int exp, input string req);
        issue(1, ch);
        store_chk(ch, exp, req);
    endtask

    task automatic t_reset_state();
        check("R11", "stall", int'(fetch_stall), 0);
        check("R11", "valid", int'(mem_wr_valid), 0);
        check("R11", "branch", int'(branch_taken), 0);
        check("R11", "flag", int'(cmp_flag), 0);
    endtask

    task automatic t_counting();
        pulse(8'h09);
        pulse(8'h01);
        pulse(8'h01);
        read_chan(0, 3, "R2");
        read_chan(3, 1, "R1");
        read_chan(5, 0, "R1");
    endtask

    task automatic t_level();
        @(negedge clk) trig_in[1] = 1'b1;
        repeat (12) @(negedge clk);
        trig_in[1] = 1'b0;
        repeat (3) @(negedge clk);
        read_chan(1, 1, "R2 level");
    endtask

    task automatic t_clear();
        issue(0, 0);
        read_chan(0, 0, "R3");
        pulse(8'h04);
        pulse(8'h04);
        // edge on channel 2 reaches the counter on the same edge as the clear
        @(negedge clk) trig_in[2] = 1'b1;
        @(negedge clk);
        @(negedge clk);
        cmd_valid = 1'b1; cmd_op = 3'd0; cmd_chan = 3'd2;
        @(negedge clk);
        cmd_valid = 1'b0;
        repeat (3) @(negedge clk);
        read_chan(2, 0, "R3 dropped edge");
        trig_in[2] = 1'b0;
        repeat (3) @(negedge clk);
        pulse(8'h04);
        read_chan(2, 1, "R3 after drop");
    endtask

    task automatic t_snapshot();
        pulse(8'h10);
        pulse(8'h10);
        issue(1, 4);
        pulse(8'h10);
        store_chk(4, 2, "R4 snapshot");
        read_chan(4, 3, "R4 new snapshot");
    endtask

    task automatic t_compare();
        for (int i = 0; i < 5; i++) pulse(8'h40);
        @(negedge clk) thr_load = 1'b1; thr_chan = 3'd6; thr_value = 8'd5;
        @(negedge clk) thr_load = 1'b0;
        issue(1, 6);
        issue(3, 6);
        check("R5", "flag at equal", int'(cmp_flag), 1);
        @(negedge clk) cmd_valid = 1'b1; cmd_op = 3'd4; cmd_chan = 3'd6;
        #1 check("R6", "branch taken", int'(branch_taken), 1);
        @(negedge clk) cmd_valid = 1'b0;
        #1 check("R6", "branch idle", int'(branch_taken), 0);
        issue(5, 6);
        check("R10", "code 5 flag", int'(cmp_flag), 1);
        check("R10", "code 5 valid", int'(mem_wr_valid), 0);
        @(negedge clk) thr_load = 1'b1; thr_value = 8'd6;
        @(negedge clk) thr_load = 1'b0;
        issue(3, 6);
        check("R5", "flag below", int'(cmp_flag), 0);
        @(negedge clk) cmd_valid = 1'b1; cmd_op = 3'd4; cmd_chan = 3'd6;
        #1 check("R6", "branch not taken", int'(branch_taken), 0);
        @(negedge clk) cmd_valid = 1'b0;
    endtask

    task automatic t_stall();
        issue(2, 6);
        check("R8", "stall raised", int'(fetch_stall), 1);
        check("R7", "data", int'(mem_wr_data), 5);
        for (int i = 0; i < 3; i++) begin
            if (i == 1) begin cmd_valid = 1'b1; cmd_op = 3'd0; cmd_chan = 3'd6; end
            @(negedge clk);
            cmd_valid = 1'b0;
            check("R8", "stall held", int'(fetch_stall), 1);
            check("R8", "addr held", int'(mem_wr_addr), exp_acc);
            check("R8", "data held", int'(mem_wr_data), 5);
        end
        mem_wr_ready = 1'b1;
        @(negedge clk);
        mem_wr_ready = 1'b0;
        check("R8", "stall released", int'(fetch_stall), 0);
        exp_acc++;
        read_chan(6, 5, "R8 ignored clear");
    endtask

    task automatic t_accumulator();
        @(negedge clk) acc_load = 1'b1; acc_value = 8'h40;
        @(negedge clk) acc_load = 1'b0;
        exp_acc = 'h40;
        read_chan(3, 1, "R9 load");
        read_chan(3, 1, "R7 step");
        issue(2, 3);
        check("R7", "addr before load", int'(mem_wr_addr), 'h42);
        mem_wr_ready = 1'b1; acc_load = 1'b1; acc_value = 8'h80;
        @(negedge clk);
        mem_wr_ready = 1'b0; acc_load = 1'b0;
        exp_acc = 'h80;
        read_chan(3, 1, "R9 load wins");
    endtask

    task automatic t_wrap();
        for (int i = 0; i < 257; i++) pulse(8'h80);
        read_chan(7, 1, "R2 wrap");
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset_state();
        rst_n = 1'b1;
        t_counting();
        t_level();
        t_clear();
        t_snapshot();
        t_compare();
        t_stall();
        t_accumulator();
        t_wrap();
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (60000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule